// File: doc/BRIEF.md
# I3C Target Address and Common-Command Unit

This block is the addressing core of a single I3C target. It sits behind the serial front end and sees the bus only as decoded byte-level events: a START or repeated START carrying a 7-bit address, written bytes, requests for a read byte, and STOP. From these events it decides whether the target acknowledges an address. It also executes the common commands that every target must support: joining dynamic address assignment, resetting, adopting or replacing its dynamic address, and returning its 48-bit provisional ID and its two characteristic bytes.

Before any assignment the target answers to its static address. Once a nonzero dynamic address is held, the static address is dropped and only the dynamic one matches. The broadcast address 0x7E is acknowledged in normal operation. During an assignment round only the broadcast address is acknowledged, and only by a target that still has no dynamic address. That target streams its ID and characteristics and then takes the next written byte as its new address.

The front end must present at most one event per cycle. `addr_ack` is a combinational response in the same cycle as `start_vld`. `rd_byte` is valid in the cycle that `rd_req` is high. All state changes take effect at the following clock edge.

Top module: `i3c_dyn_addr_unit`

## Requirements
- R1: After reset the dynamic address is 0, `addr_ack` is low and `rd_byte` reads 0xFF.
- R2: Outside an assignment round, the block acknowledges the broadcast address 0x7E. While the dynamic address is 0 it also acknowledges the static address. Once the dynamic address is nonzero, the dynamic address is the only other address it acknowledges. Every other address is not acknowledged.
- R3: Writing code 0x07 as the first byte after a broadcast START opens an assignment round that lasts until STOP. Within the round only 0x7E is acknowledged, and only while the dynamic address is 0.
- R4: In an assignment round, successive reads return the six ID bytes least significant first, then the bus-characteristic byte, then the device-characteristic byte. Each read advances one position. Reads after the eighth byte return 0xFF.
- R5: After all eight bytes have been read in an assignment round, the next written byte supplies the new dynamic address in its bits 6:0. The command state then returns to idle.
- R6: Code 0x06 clears the dynamic address to 0.
- R7: Code 0x29 and code 0x87 each copy the static address into the dynamic address.
- R8: After code 0x88, a repeated START to the current address followed by a written byte loads bits 6:0 of that byte as the dynamic address.
- R9: After code 0x8D, a direct read returns the six ID bytes least significant first and then 0xFF. After code 0x8E or 0x8F, every read returns the bus-characteristic or device-characteristic byte respectively.
- R10: Only the first byte written after a broadcast START with no command open is taken as a command code. Writes to the target's own address with no command open do not change the dynamic address, and neither do writes while the target is not selected. Reads with no command open return 0xFF.
- R11: STOP closes any command and any assignment round and deselects the target. A broadcast START outside an assignment round discards the open command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_addr | input | 7 | Static address |
| prov_id | input | 48 | Provisional ID, byte 0 sent first |
| bcr_val | input | 8 | Bus-characteristic byte |
| dcr_val | input | 8 | Device-characteristic byte |
| start_vld | input | 1 | START or repeated START event |
| start_addr | input | 7 | Address sent with the START |
| wr_vld | input | 1 | Written-byte event |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | Read-byte request |
| stop_vld | input | 1 | STOP event |
| addr_ack | output | 1 | Address acknowledged (same cycle as start_vld) |
| rd_byte | output | 8 | Byte returned for rd_req, 0xFF otherwise |
| dyn_addr | output | 7 | Current dynamic address, 0 when unassigned |

## Verification
The bench targets the switch from static to dynamic matching. A design that still matched the static address after assignment would acknowledge 0x2A where it must stay silent. It also targets an assigned target's withdrawal from a later assignment round; getting that wrong shows up as a broadcast acknowledge that collides on the bus. The ninth read of an assignment round must return 0xFF and must not disturb the position at which the written address is taken. Private writes and writes made while the target is unselected must not be mistaken for command codes. A design that confused them would change its address on ordinary data.

// File: rtl/i3c_dyn_addr_unit.sv
module i3c_dyn_addr_unit #(
  parameter int AW = 7,
  parameter int IDB = 6,
  parameter logic [AW-1:0] BCAST_ADDR = 7'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     static_addr,
  input  logic [8*IDB-1:0]  prov_id,
  input  logic [7:0]        bcr_val,
  input  logic [7:0]        dcr_val,
  input  logic              start_vld,
  input  logic [AW-1:0]     start_addr,
  input  logic              wr_vld,
  input  logic [7:0]        wr_byte,
  input  logic              rd_req,
  input  logic              stop_vld,
  output logic              addr_ack,
  output logic [7:0]        rd_byte,
  output logic [AW-1:0]     dyn_addr
);
  localparam int OFFW = $clog2(IDB + 3);
  localparam logic [OFFW-1:0] OFF_CHB = OFFW'(IDB);
  localparam logic [OFFW-1:0] OFF_CHD = OFFW'(IDB + 1);
  localparam logic [OFFW-1:0] OFF_END = OFFW'(IDB + 2);

  localparam logic [7:0] C_DAA   = 8'h07;
  localparam logic [7:0] C_CLR   = 8'h06;
  localparam logic [7:0] C_ALLST = 8'h29;
  localparam logic [7:0] C_ONEST = 8'h87;
  localparam logic [7:0] C_NEW   = 8'h88;
  localparam logic [7:0] C_ID    = 8'h8D;
  localparam logic [7:0] C_BCH   = 8'h8E;
  localparam logic [7:0] C_DCH   = 8'h8F;

  logic [AW-1:0]   dyn_q;
  logic            sel_q, bc_q, daa_q, ccc_on_q;
  logic [7:0]      code_q;
  logic [OFFW-1:0] off_q;

  logic [AW-1:0] match_addr;
  logic          is_bc, has_dyn, rd_adv;
  logic [7:0]    id_byte, rd_val;

  assign has_dyn    = dyn_q != '0;
  assign match_addr = has_dyn ? dyn_q : static_addr;
  assign is_bc      = start_addr == BCAST_ADDR;
  assign addr_ack   = start_vld && (daa_q ? (is_bc && !has_dyn)
                                          : (is_bc || start_addr == match_addr));
  assign dyn_addr   = dyn_q;

  always_comb begin
    id_byte = 8'hFF;
    for (int i = 0; i < IDB; i++)
      if (off_q == OFFW'(i)) id_byte = prov_id[i*8 +: 8];
  end

  always_comb begin
    rd_val = 8'hFF;
    rd_adv = 1'b0;
    if (sel_q && ccc_on_q) begin
      case (code_q)
        C_DAA: begin
          rd_adv = off_q < OFF_END;
          if (off_q < OFF_CHB)       rd_val = id_byte;
          else if (off_q == OFF_CHB) rd_val = bcr_val;
          else if (off_q == OFF_CHD) rd_val = dcr_val;
        end
        C_ID: begin
          rd_adv = off_q < OFF_CHB;
          if (off_q < OFF_CHB) rd_val = id_byte;
        end
        C_BCH:   rd_val = bcr_val;
        C_DCH:   rd_val = dcr_val;
        default: rd_val = 8'hFF;
      endcase
    end
  end

  assign rd_byte = rd_req ? rd_val : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dyn_q    <= '0;
      sel_q    <= 1'b0;
      bc_q     <= 1'b0;
      daa_q    <= 1'b0;
      ccc_on_q <= 1'b0;
      code_q   <= '0;
      off_q    <= '0;
    end else if (stop_vld) begin
      sel_q    <= 1'b0;
      bc_q     <= 1'b0;
      daa_q    <= 1'b0;
      ccc_on_q <= 1'b0;
      code_q   <= '0;
      off_q    <= '0;
    end else if (start_vld) begin
      sel_q <= addr_ack;
      bc_q  <= is_bc;
      if (is_bc && !daa_q) begin
        ccc_on_q <= 1'b0;
        code_q   <= '0;
        off_q    <= '0;
      end
    end else if (wr_vld && sel_q) begin
      if (!ccc_on_q) begin
        if (bc_q) begin
          code_q   <= wr_byte;
          ccc_on_q <= 1'b1;
          if (wr_byte == C_DAA) daa_q <= 1'b1;
          if (wr_byte == C_CLR) dyn_q <= '0;
          if (wr_byte == C_ALLST || wr_byte == C_ONEST) dyn_q <= static_addr;
        end
      end else begin
        case (code_q)
          C_DAA: if (off_q == OFF_END) begin
            dyn_q    <= wr_byte[AW-1:0];
            ccc_on_q <= 1'b0;
            code_q   <= '0;
            off_q    <= '0;
          end
          C_CLR:            dyn_q <= '0;
          C_ALLST, C_ONEST: dyn_q <= static_addr;
          C_NEW:            dyn_q <= wr_byte[AW-1:0];
          default: ;
        endcase
      end
    end else if (rd_req && rd_adv) begin
      off_q <= off_q + OFFW'(1);
    end
  end

  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_vld, wr_vld, rd_req, stop_vld}));

  assert_assigned_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (daa_q && has_dyn && start_vld) |-> !addr_ack);

  assert_dyn_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_q != $past(dyn_q)) |-> $past(wr_vld && sel_q && !start_vld && !stop_vld));

  assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_vld |=> (!sel_q && !ccc_on_q && !daa_q && off_q == '0));

  assert_off_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) |-> (off_q == '0 || off_q == $past(off_q) + OFFW'(1)));

  assert_off_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OFF_END);
endmodule

// File: tb/i3c_dyn_addr_unit_tb.sv
module i3c_dyn_addr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] static_addr = 7'h2A;
  logic [47:0] prov_id = 48'hA1B2C3D4E5F6;
  logic [7:0] bcr_val = 8'h46;
  logic [7:0] dcr_val = 8'h5C;
  logic start_vld = 0, wr_vld = 0, rd_req = 0, stop_vld = 0;
  logic [6:0] start_addr = '0;
  logic [7:0] wr_byte = '0;
  logic addr_ack;
  logic [7:0] rd_byte;
  logic [6:0] dyn_addr;

  int checks = 0, errors = 0;
  int m_dyn = 0, m_code = 0, m_off = 0;
  bit m_sel = 0, m_bc = 0, m_daa = 0, m_on = 0;
  int last_ack, last_rd, last_dyn;
  byte unsigned id_q[$];

  always #4 clk = ~clk;

  i3c_dyn_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .static_addr(static_addr), .prov_id(prov_id),
    .bcr_val(bcr_val), .dcr_val(dcr_val), .start_vld(start_vld),
    .start_addr(start_addr), .wr_vld(wr_vld), .wr_byte(wr_byte),
    .rd_req(rd_req), .stop_vld(stop_vld), .addr_ack(addr_ack),
    .rd_byte(rd_byte), .dyn_addr(dyn_addr));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int m_ack(bit st, int a);
    if (!st) return 0;
    if (m_daa) return (a == 'h7E && m_dyn == 0) ? 1 : 0;
    return (a == 'h7E || a == ((m_dyn != 0) ? m_dyn : int'(static_addr))) ? 1 : 0;
  endfunction

  function automatic int m_rd(bit rd);
    if (!rd || !m_sel || !m_on) return 'hFF;
    if (m_code == 'h07 || m_code == 'h8D) begin
      if (m_off < id_q.size()) return id_q[m_off];
      if (m_code == 'h07 && m_off == 6) return bcr_val;
      if (m_code == 'h07 && m_off == 7) return dcr_val;
      return 'hFF;
    end
    if (m_code == 'h8E) return bcr_val;
    if (m_code == 'h8F) return dcr_val;
    return 'hFF;
  endfunction

  task automatic m_step(bit st, int a, bit wr, int d, bit rd, bit sp);
    int ack;
    ack = m_ack(st, a);
    if (sp) begin
      m_sel = 0; m_bc = 0; m_daa = 0; m_on = 0; m_code = 0; m_off = 0;
    end else if (st) begin
      m_sel = (ack != 0); m_bc = (a == 'h7E);
      if (m_bc && !m_daa) begin m_on = 0; m_code = 0; m_off = 0; end
    end else if (wr && m_sel) begin
      if (!m_on) begin
        if (m_bc) begin
          m_code = d; m_on = 1;
          if (d == 'h07) m_daa = 1;
          if (d == 'h06) m_dyn = 0;
          if (d == 'h29 || d == 'h87) m_dyn = static_addr;
        end
      end else if (m_code == 'h07) begin
        if (m_off == 8) begin m_dyn = d & 'h7F; m_on = 0; m_code = 0; m_off = 0; end
      end else if (m_code == 'h06) m_dyn = 0;
      else if (m_code == 'h29 || m_code == 'h87) m_dyn = static_addr;
      else if (m_code == 'h88) m_dyn = d & 'h7F;
    end else if (rd && m_sel && m_on) begin
      if ((m_code == 'h07 && m_off < 8) || (m_code == 'h8D && m_off < 6)) m_off++;
    end
  endtask

  task automatic cyc(bit st, int a, bit wr, int d, bit rd, bit sp);
    @(negedge clk);
    start_vld = st; start_addr = a[6:0]; wr_vld = wr; wr_byte = d[7:0];
    rd_req = rd; stop_vld = sp;
    #1;
    last_ack = addr_ack; last_rd = rd_byte; last_dyn = dyn_addr;
    chk("R2 model ack", last_ack, m_ack(st, a));
    chk("R4 model rd", last_rd, m_rd(rd));
    chk("R6 model dyn", last_dyn, m_dyn);
    m_step(st, a, wr, d, rd, sp);
    @(posedge clk);
  endtask

  task automatic start(int a);  cyc(1, a, 0, 0, 0, 0); endtask
  task automatic wr(int d);     cyc(0, 0, 1, d, 0, 0); endtask
  task automatic rd();          cyc(0, 0, 0, 0, 1, 0); endtask
  task automatic stop();        cyc(0, 0, 0, 0, 0, 1); endtask
  task automatic idle();        cyc(0, 0, 0, 0, 0, 0); endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    for (int i = 0; i < 6; i++) id_q.push_back(prov_id[i*8 +: 8]);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset dyn", dyn_addr, 0);
    chk("R1 reset rd", rd_byte, 'hFF);
    chk("R1 reset ack", addr_ack, 0);
    @(negedge clk) rst_n = 1'b1;

    start('h2A); chk("R2 static ack", last_ack, 1);
    start('h33); chk("R2 other nack", last_ack, 0);
    start('h7E); chk("R2 bcast ack", last_ack, 1);
    stop();

    start('h2A); wr('h55); idle(); chk("R10 private write", last_dyn, 0);
    rd(); chk("R10 read no ccc", last_rd, 'hFF);
    stop();

    start('h7E); wr('h07); start('h7E); chk("R3 daa ack", last_ack, 1);
    for (int i = 0; i < 6; i++) begin rd(); chk("R4 id byte", last_rd, id_q[i]); end
    rd(); chk("R4 bcr", last_rd, 'h46);
    rd(); chk("R4 dcr", last_rd, 'h5C);
    rd(); chk("R4 past end", last_rd, 'hFF);
    wr('hB1); idle(); chk("R5 assigned", last_dyn, 'h31);
    start('h7E); chk("R3 assigned nack", last_ack, 0);
    stop();

    start('h2A); chk("R2 static dropped", last_ack, 0);
    start('h31); chk("R2 dyn ack", last_ack, 1);
    stop();

    start('h7E); wr('h8D); start('h31);
    for (int i = 0; i < 6; i++) begin rd(); chk("R9 pid byte", last_rd, id_q[i]); end
    rd(); chk("R9 pid end", last_rd, 'hFF);
    stop();
    start('h7E); wr('h8E); start('h31);
    rd(); chk("R9 bcr", last_rd, 'h46);
    rd(); chk("R9 bcr again", last_rd, 'h46);
    stop();
    start('h7E); wr('h8F); start('h31);
    rd(); chk("R9 dcr", last_rd, 'h5C);
    stop();

    start('h31); rd(); chk("R11 stop cleared", last_rd, 'hFF);
    stop();
    start('h7E); wr('h8E); start('h7E); rd(); chk("R11 bcast restart", last_rd, 'hFF);
    stop();

    start('h7E); wr('h88); start('h31); chk("R8 direct ack", last_ack, 1);
    wr('h44); idle(); chk("R8 new addr", last_dyn, 'h44);
    stop();
    start('h44); chk("R2 new addr ack", last_ack, 1);
    stop();

    start('h7E); wr('h06); idle(); chk("R6 cleared", last_dyn, 0);
    stop();
    start('h7E); wr('h29); idle(); chk("R7 aasa", last_dyn, 'h2A);
    stop();
    start('h7E); wr('h06); stop();
    start('h7E); wr('h87); idle(); chk("R7 dasa", last_dyn, 'h2A);
    stop();

    start('h7E); wr('h07); start('h7E); chk("R3 withdraw", last_ack, 0);
    start('h2A); chk("R3 direct in daa", last_ack, 0);
    wr('h11); idle(); chk("R10 unselected write", last_dyn, 'h2A);
    stop();

    start('h7E); wr('h06); stop();
    start('h7E); wr('h07); start('h2A); chk("R3 non-bcast in daa", last_ack, 0);
    stop();
    start('h2A); chk("R11 daa closed", last_ack, 1);
    stop();
    idle();
    summary();
  end
endmodule